// File: doc/BRIEF.md
# SATA Transport Control Register File

This block is the processor-facing register set for one SATA transport channel. An AXI4-Lite slave port lets software program three 512-byte-aligned memory addresses and a control word. The control word carries the transmit length, the frame kind and two command bits. The block turns the command bits into single-cycle start and reset pulses for the data-movement engines, and it presents the stored addresses and transmit parameters on plain output ports.

Status flows the other way. The engines report the received word count, the kind of the last received frame, an error code and two completion events. The read side of the register map shares some offsets with the write side but maps to different registers there, so a read at such an offset returns status and never the value that was written. Writes have side effects: any control write zeroes the received word count, and an interrupt-clear word removes the received-frame-kind flag and each of the two sticky interrupt flags bit by bit.

Top module: `sata_xport_regs`

## Requirements
- R1: After reset all address outputs, `tx_len`, `tx_is_data`, `tx_start`, `hw_rst`, both interrupt flags, `irq`, `s_bvalid` and `s_rvalid` are zero.
- R2: Writes to offset 0x00, 0x04 and 0x0C load `tx_addr`, `rx_ndata_addr` and `rx_data_addr`. Bits 8:0 of each stored address are always zero, whatever value is written.
- R3: A write to offset 0x08 stores bit 29 in `tx_is_data` (1 = data frame) and bits 15:0 in `tx_len`. Both hold until the next control write.
- R4: Control bit 30 gives a `tx_start` pulse and control bit 31 gives an `hw_rst` pulse. Each pulse lasts exactly one cycle, in the cycle after the write is accepted. Neither bit is stored.
- R5: A read at 0x04 returns `err_code`. A read at 0x0C returns the last-frame-kind flag in bit 31, zeros in bits 30:24 and the receive count in bits 23:0. A read at 0x10 returns the VERSION parameter. Every other offset in the 256-byte window, including the write-only offsets 0x00 and 0x08, reads as zero, and no read returns a written value.
- R6: Any write to offset 0x08 clears the receive count. This clear takes priority over a `rx_cnt_load` in the same cycle.
- R7: `rx_cnt_load` loads `rx_cnt_val` into the receive count. `rx_type_load` loads `rx_type_nd` into the last-frame-kind flag (1 = non-data). Writing 1 to bit 29 at offset 0x10 clears that flag, and the clear takes priority over a load in the same cycle.
- R8: `d2p_done` sets `irq_d2p` and `p2d_done` sets `irq_p2d`. Writing 1 to bit 31 or bit 30 at offset 0x10 clears `irq_d2p` or `irq_p2d` respectively. A set event in the same cycle as its clear wins. `irq` is the OR of the two flags.
- R9: Every response is OKAY (0). `s_bvalid` stays high until `s_bready`. `s_rvalid` and `s_rdata` stay high and stable until `s_rready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | AXI_AW | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | AXI_AW | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| tx_addr | output | MEM_AW | Transmit start address |
| rx_ndata_addr | output | MEM_AW | Non-data frame receive address |
| rx_data_addr | output | MEM_AW | Data frame receive address |
| tx_len | output | LEN_W | Transmit length in 32-bit words |
| tx_is_data | output | 1 | Transmit frame kind, 1 = data |
| tx_start | output | 1 | Transmit start pulse |
| hw_rst | output | 1 | Channel reset pulse |
| rx_cnt_val | input | CNT_W | Received word count from engine |
| rx_cnt_load | input | 1 | Load strobe for rx_cnt_val |
| rx_type_nd | input | 1 | Last frame was non-data |
| rx_type_load | input | 1 | Load strobe for rx_type_nd |
| err_code | input | 32 | Error code from link layer |
| d2p_done | input | 1 | Device-to-processor completion event |
| p2d_done | input | 1 | Processor-to-device completion event |
| irq_d2p | output | 1 | Sticky device-to-processor flag |
| irq_p2d | output | 1 | Sticky processor-to-device flag |
| irq | output | 1 | Combined interrupt |

## Verification
The in-RTL properties check on every cycle that the start pulse never lasts two cycles, that a control write leaves the count at zero, and that a frame-kind clear leaves the flag low. They also check that an interrupt set always wins and that a clear without a set drops the flag, and that pending responses stay stable. Only the bench's scenarios can show the split between the read and write maps. It does this by sweeping every offset of the window after loading every writable register with all ones. The bench scenarios also cover the forced alignment of the address bits for several data patterns, the exact cycle of each pulse, and the values that travel from the control word and the status inputs to the outputs.

// File: rtl/sxr_pkg.sv
package sxr_pkg;
   localparam int OFS_W = 8;
   localparam logic [OFS_W-1:0] OFS_TXADDR  = 8'h00;
   localparam logic [OFS_W-1:0] OFS_RXNADDR = 8'h04;
   localparam logic [OFS_W-1:0] OFS_CTRL    = 8'h08;
   localparam logic [OFS_W-1:0] OFS_RXDADDR = 8'h0C;
   localparam logic [OFS_W-1:0] OFS_ICLR    = 8'h10;
   localparam logic [OFS_W-1:0] OFS_ERR     = 8'h04;
   localparam logic [OFS_W-1:0] OFS_RXCNT   = 8'h0C;
   localparam logic [OFS_W-1:0] OFS_VER     = 8'h10;
   localparam int N_ADDR = 3;
   localparam logic [OFS_W-1:0] ADDR_OFS [N_ADDR] = '{OFS_TXADDR, OFS_RXNADDR, OFS_RXDADDR};
   localparam int BIT_RST   = 31;
   localparam int BIT_START = 30;
   localparam int BIT_KIND  = 29;
   localparam int BIT_CLR_D2P  = 31;
   localparam int BIT_CLR_P2D  = 30;
   localparam int BIT_CLR_KIND = 29;
   localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/sxr_axil_slave.sv
module sxr_axil_slave
   import sxr_pkg::*;
#(
   parameter int AXI_AW = 12,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AXI_AW-1:0] s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   input  logic [AXI_AW-1:0] s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic              wr_en,
   output logic [OFS_W-1:0]  wr_ofs,
   output logic [DATA_W-1:0] wr_data,
   output logic [OFS_W-1:0]  rd_ofs,
   input  logic [DATA_W-1:0] rd_data
);
   if (AXI_AW < OFS_W) begin : g_bad_aw
      $error("AXI_AW must cover the register window");
   end

   logic bvalid_q, rvalid_q;
   logic [DATA_W-1:0] rdata_q;
   logic rd_take;

   assign s_awready = s_awvalid && s_wvalid && !bvalid_q;
   assign s_wready  = s_awready;
   assign wr_en     = s_awready;
   assign wr_ofs    = s_awaddr[OFS_W-1:0];
   assign wr_data   = s_wdata;

   assign s_arready = !rvalid_q;
   assign rd_take   = s_arvalid && !rvalid_q;
   assign rd_ofs    = s_araddr[OFS_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bvalid_q <= 1'b0;
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         if (wr_en) bvalid_q <= 1'b1;
         else if (s_bready) bvalid_q <= 1'b0;
         if (rd_take) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_data;
         end else if (s_rready) begin
            rvalid_q <= 1'b0;
         end
      end
   end

   assign s_bvalid = bvalid_q;
   assign s_rvalid = rvalid_q;
   assign s_rdata  = rdata_q;
   assign s_bresp  = RESP_OKAY;
   assign s_rresp  = RESP_OKAY;

   AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid && !s_bready |=> s_bvalid); // R9
   AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata)); // R9
endmodule

// File: rtl/sxr_irq_flags.sv
module sxr_irq_flags #(
   parameter int N_IRQ = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] set_ev,
   input  logic [N_IRQ-1:0] clr_req,
   output logic [N_IRQ-1:0] flags,
   output logic             irq_any
);
   if (N_IRQ < 1) begin : g_bad_n
      $error("N_IRQ must be at least 1");
   end

   for (genvar i = 0; i < N_IRQ; i++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk) begin
         if (!rst_n)          f_q <= 1'b0;
         else if (set_ev[i])  f_q <= 1'b1;
         else if (clr_req[i]) f_q <= 1'b0;
      end
      assign flags[i] = f_q;

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_ev[i] |=> flags[i]); // R8
      AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         clr_req[i] && !set_ev[i] |=> !flags[i]); // R8
   end

   assign irq_any = |flags;
endmodule

// File: rtl/sxr_reg_core.sv
module sxr_reg_core
   import sxr_pkg::*;
#(
   parameter int          DATA_W  = 32,
   parameter int          MEM_AW  = 32,
   parameter int          ALIGN   = 9,
   parameter int          LEN_W   = 16,
   parameter int          CNT_W   = 24,
   parameter logic [31:0] VERSION = 32'h0000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFS_W-1:0]  wr_ofs,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [OFS_W-1:0]  rd_ofs,
   output logic [DATA_W-1:0] rd_data,
   output logic [MEM_AW-1:0] addr_out [N_ADDR],
   output logic [LEN_W-1:0]  tx_len,
   output logic              tx_is_data,
   output logic              tx_start,
   output logic              hw_rst,
   input  logic [CNT_W-1:0]  rx_cnt_val,
   input  logic              rx_cnt_load,
   input  logic              rx_type_nd,
   input  logic              rx_type_load,
   input  logic [31:0]       err_code,
   output logic              clr_d2p,
   output logic              clr_p2d
);
   if (DATA_W != 32)                      begin : g_bad_dw  $error("DATA_W must be 32"); end
   if (MEM_AW > DATA_W || ALIGN >= MEM_AW) begin : g_bad_aw  $error("bad MEM_AW/ALIGN"); end
   if (LEN_W < 1 || LEN_W > 16)           begin : g_bad_len $error("LEN_W out of range"); end
   if (CNT_W < 1 || CNT_W > 24)           begin : g_bad_cnt $error("CNT_W out of range"); end

   localparam int HI_W = MEM_AW - ALIGN;

   logic ctl_we, iclr_we, kind_clr;
   assign ctl_we   = wr_en && (wr_ofs == OFS_CTRL);
   assign iclr_we  = wr_en && (wr_ofs == OFS_ICLR);
   assign kind_clr = iclr_we && wr_data[BIT_CLR_KIND];
   assign clr_d2p  = iclr_we && wr_data[BIT_CLR_D2P];
   assign clr_p2d  = iclr_we && wr_data[BIT_CLR_P2D];

   // aligned address registers; only the upper bits are stored
   for (genvar i = 0; i < N_ADDR; i++) begin : g_addr
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk) begin
         if (!rst_n) hi_q <= '0;
         else if (wr_en && wr_ofs == ADDR_OFS[i]) hi_q <= wr_data[MEM_AW-1:ALIGN];
      end
      assign addr_out[i] = {hi_q, {ALIGN{1'b0}}};
   end

   logic [LEN_W-1:0] len_q;
   logic kind_q, start_q, rst_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q   <= '0;
         kind_q  <= 1'b0;
         start_q <= 1'b0;
         rst_q   <= 1'b0;
      end else begin
         start_q <= ctl_we && wr_data[BIT_START];
         rst_q   <= ctl_we && wr_data[BIT_RST];
         if (ctl_we) begin
            len_q  <= wr_data[LEN_W-1:0];
            kind_q <= wr_data[BIT_KIND];
         end
      end
   end
   assign tx_len     = len_q;
   assign tx_is_data = kind_q;
   assign tx_start   = start_q;
   assign hw_rst     = rst_q;

   logic [CNT_W-1:0] cnt_q;
   logic nd_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         nd_q  <= 1'b0;
      end else begin
         if (ctl_we)           cnt_q <= '0;
         else if (rx_cnt_load) cnt_q <= rx_cnt_val;
         if (kind_clr)          nd_q <= 1'b0;
         else if (rx_type_load) nd_q <= rx_type_nd;
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_ofs)
         OFS_ERR:   rd_data = err_code;
         OFS_RXCNT: begin
            rd_data[31]        = nd_q;
            rd_data[CNT_W-1:0] = cnt_q;
         end
         OFS_VER:   rd_data = VERSION;
         default:   rd_data = '0;
      endcase
   end

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start); // R4
   AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      hw_rst |=> !hw_rst); // R4
   AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> cnt_q == '0); // R6
   AST_KIND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      kind_clr |=> !nd_q); // R7
endmodule

// File: rtl/sata_xport_regs.sv
module sata_xport_regs
   import sxr_pkg::*;
#(
   parameter int          AXI_AW  = 12,
   parameter int          MEM_AW  = 32,
   parameter int          ALIGN   = 9,
   parameter int          LEN_W   = 16,
   parameter int          CNT_W   = 24,
   parameter logic [31:0] VERSION = 32'h5A7A_0311
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AXI_AW-1:0] s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [31:0]       s_wdata,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   input  logic [AXI_AW-1:0] s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [31:0]       s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic [MEM_AW-1:0] tx_addr,
   output logic [MEM_AW-1:0] rx_ndata_addr,
   output logic [MEM_AW-1:0] rx_data_addr,
   output logic [LEN_W-1:0]  tx_len,
   output logic              tx_is_data,
   output logic              tx_start,
   output logic              hw_rst,
   input  logic [CNT_W-1:0]  rx_cnt_val,
   input  logic              rx_cnt_load,
   input  logic              rx_type_nd,
   input  logic              rx_type_load,
   input  logic [31:0]       err_code,
   input  logic              d2p_done,
   input  logic              p2d_done,
   output logic              irq_d2p,
   output logic              irq_p2d,
   output logic              irq
);
   localparam int DATA_W = 32;

   logic              wr_en;
   logic [OFS_W-1:0]  wr_ofs, rd_ofs;
   logic [DATA_W-1:0] wr_data, rd_data;
   logic [MEM_AW-1:0] addr_vec [N_ADDR];
   logic              clr_d2p, clr_p2d;
   logic [1:0]        flags;

   sxr_axil_slave #(.AXI_AW(AXI_AW), .DATA_W(DATA_W)) u_axil (
      .clk, .rst_n,
      .s_awaddr, .s_awvalid, .s_awready, .s_wdata, .s_wvalid, .s_wready,
      .s_bresp, .s_bvalid, .s_bready,
      .s_araddr, .s_arvalid, .s_arready, .s_rdata, .s_rresp, .s_rvalid, .s_rready,
      .wr_en, .wr_ofs, .wr_data, .rd_ofs, .rd_data
   );

   sxr_reg_core #(.DATA_W(DATA_W), .MEM_AW(MEM_AW), .ALIGN(ALIGN), .LEN_W(LEN_W),
                  .CNT_W(CNT_W), .VERSION(VERSION)) u_core (
      .clk, .rst_n, .wr_en, .wr_ofs, .wr_data, .rd_ofs, .rd_data,
      .addr_out(addr_vec), .tx_len, .tx_is_data, .tx_start, .hw_rst,
      .rx_cnt_val, .rx_cnt_load, .rx_type_nd, .rx_type_load, .err_code,
      .clr_d2p, .clr_p2d
   );

   sxr_irq_flags #(.N_IRQ(2)) u_irq (
      .clk, .rst_n,
      .set_ev({p2d_done, d2p_done}),
      .clr_req({clr_p2d, clr_d2p}),
      .flags, .irq_any(irq)
   );

   assign tx_addr       = addr_vec[0];
   assign rx_ndata_addr = addr_vec[1];
   assign rx_data_addr  = addr_vec[2];
   assign irq_d2p       = flags[0];
   assign irq_p2d       = flags[1];
endmodule

// File: tb/sata_xport_regs_tb.sv
module sata_xport_regs_tb;
   localparam logic [31:0] VER = 32'h5A7A_0311;

   logic clk = 0, rst_n = 0;
   always #2 clk = ~clk;

   logic [11:0] s_awaddr = '0, s_araddr = '0;
   logic s_awvalid = 0, s_wvalid = 0, s_bready = 1, s_arvalid = 0, s_rready = 0;
   logic [31:0] s_wdata = '0;
   logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
   logic [1:0] s_bresp, s_rresp;
   logic [31:0] s_rdata;
   logic [31:0] tx_addr, rx_ndata_addr, rx_data_addr;
   logic [15:0] tx_len;
   logic tx_is_data, tx_start, hw_rst, irq_d2p, irq_p2d, irq;
   logic [23:0] rx_cnt_val = '0;
   logic rx_cnt_load = 0, rx_type_nd = 0, rx_type_load = 0, d2p_done = 0, p2d_done = 0;
   logic [31:0] err_code = 32'hDEAD_0042;

   sata_xport_regs u_dut (.*);

   int n_chk = 0, n_fail = 0;
   logic p_start, p_rst, p_start2, p_rst2;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      s_awaddr = {4'h0, a}; s_wdata = d; s_awvalid = 1; s_wvalid = 1;
      @(posedge clk);
      @(negedge clk);
      s_awvalid = 0; s_wvalid = 0;
      chk("R9 bvalid", {31'b0, s_bvalid}, 32'd1);
      chk("R9 bresp", {30'b0, s_bresp}, 32'd0);
      p_start = tx_start; p_rst = hw_rst;
      @(posedge clk);
      @(negedge clk);
      p_start2 = tx_start; p_rst2 = hw_rst;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      s_araddr = {4'h0, a}; s_arvalid = 1; s_rready = 0;
      @(posedge clk);
      @(negedge clk);
      s_arvalid = 0;
      d = s_rdata;
      @(posedge clk);
      @(negedge clk);
      if (s_rvalid !== 1'b1 || s_rdata !== d) chk("R9 rdata hold", s_rdata, d ^ 32'h1);
      s_rready = 1;
      @(posedge clk);
      @(negedge clk);
      s_rready = 0;
   endtask

   task automatic pulse_ev(input int which);
      @(negedge clk);
      if (which == 0) d2p_done = 1; else p2d_done = 1;
      @(negedge clk);
      d2p_done = 0; p2d_done = 0;
   endtask

   initial begin
      #200000;
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [31:0] pats [3];
      pats = '{32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h1234_5678};
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R1 reset state
      chk("R1 addrs", tx_addr | rx_ndata_addr | rx_data_addr, 32'd0);
      chk("R1 ctl", {tx_len, 12'b0, tx_is_data, tx_start, hw_rst, irq}, 32'd0);
      chk("R1 flags/valid", {26'b0, irq_d2p, irq_p2d, s_bvalid, s_rvalid, 2'b0}, 32'd0);

      // R2 alignment sweep over patterns
      foreach (pats[i]) begin
         wr(8'h00, pats[i]);
         wr(8'h04, pats[i] ^ 32'h0F0F_0F0F);
         wr(8'h0C, ~pats[i]);
         chk("R2 tx_addr", tx_addr, pats[i] & 32'hFFFF_FE00);
         chk("R2 rx_ndata_addr", rx_ndata_addr, (pats[i] ^ 32'h0F0F_0F0F) & 32'hFFFF_FE00);
         chk("R2 rx_data_addr", rx_data_addr, ~pats[i] & 32'hFFFF_FE00);
      end

      // R3/R4 control combinations of bits 31:29
      for (int c = 0; c < 8; c++) begin
         logic [31:0] w;
         w = {c[2:0], 13'h0, 16'(16'h1000 + c * 257)};
         wr(8'h08, w);
         chk("R3 tx_len", {16'b0, tx_len}, {16'b0, w[15:0]});
         chk("R3 tx_is_data", {31'b0, tx_is_data}, {31'b0, w[29]});
         chk("R4 start pulse", {30'b0, p_start, p_start2}, {30'b0, w[30], 1'b0});
         chk("R4 rst pulse", {30'b0, p_rst, p_rst2}, {30'b0, w[31], 1'b0});
      end

      // R7 load count and kind
      @(negedge clk);
      rx_cnt_val = 24'hABCDEF; rx_cnt_load = 1; rx_type_nd = 1; rx_type_load = 1;
      @(negedge clk);
      rx_cnt_load = 0; rx_type_load = 0;
      rd(8'h0C, d);
      chk("R7 count+kind read", d, 32'h80AB_CDEF);

      // R5 full read sweep after writing all ones everywhere writable
      wr(8'h00, '1); wr(8'h04, '1); wr(8'h0C, '1);
      for (int o = 0; o < 256; o += 4) begin
         logic [31:0] e;
         rd(8'(o), d);
         e = (o == 4) ? err_code : (o == 12) ? 32'h80AB_CDEF : (o == 16) ? VER : 32'd0;
         chk($sformatf("R5 read ofs %0h", o), d, e);
      end
      err_code = 32'h0000_7E57;
      rd(8'h04, d);
      chk("R5 err_code live", d, 32'h0000_7E57);

      // R6 control write clears count, kind kept
      wr(8'h08, 32'h0000_0004);
      rd(8'h0C, d);
      chk("R6 count cleared", d, 32'h8000_0000);

      // R6 clear wins over a simultaneous load
      @(negedge clk);
      s_awaddr = 12'h008; s_wdata = 32'h0; s_awvalid = 1; s_wvalid = 1;
      rx_cnt_val = 24'h000055; rx_cnt_load = 1;
      @(negedge clk);
      s_awvalid = 0; s_wvalid = 0; rx_cnt_load = 0;
      @(negedge clk);
      rd(8'h0C, d);
      chk("R6 clear beats load", d, 32'h8000_0000);

      // R7 clear wins over a simultaneous kind load
      @(negedge clk);
      s_awaddr = 12'h010; s_wdata = 32'h2000_0000; s_awvalid = 1; s_wvalid = 1;
      rx_type_nd = 1; rx_type_load = 1;
      @(negedge clk);
      s_awvalid = 0; s_wvalid = 0; rx_type_load = 0;
      @(negedge clk);
      rd(8'h0C, d);
      chk("R7 kind cleared", d, 32'h0000_0000);

      // R8 interrupts
      pulse_ev(0);
      chk("R8 d2p set", {29'b0, irq_d2p, irq_p2d, irq}, 32'b101);
      pulse_ev(1);
      chk("R8 both set", {29'b0, irq_d2p, irq_p2d, irq}, 32'b111);
      wr(8'h10, 32'h8000_0000);
      chk("R8 clear d2p only", {29'b0, irq_d2p, irq_p2d, irq}, 32'b011);
      wr(8'h10, 32'h4000_0000);
      chk("R8 clear p2d", {29'b0, irq_d2p, irq_p2d, irq}, 32'b000);
      // set beats clear
      @(negedge clk);
      s_awaddr = 12'h010; s_wdata = 32'hC000_0000; s_awvalid = 1; s_wvalid = 1;
      d2p_done = 1;
      @(negedge clk);
      s_awvalid = 0; s_wvalid = 0; d2p_done = 0;
      chk("R8 set beats clear", {29'b0, irq_d2p, irq_p2d, irq}, 32'b101);
      @(negedge clk);
      // writes to read-only effect offsets leave addresses unchanged
      wr(8'h10, 32'h0000_0000);
      chk("R8 zero clear no effect", {31'b0, irq_d2p}, 32'd1);
      chk("R2 unaffected", tx_addr, 32'hFFFF_FE00);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule